// File: doc/BRIEF.md
# Serial Descrambler with Idle-Based Lock Monitor

This block sits in the 100 Mbit/s receive path, directly after clock and data recovery. It takes the recovered serial bit stream one bit per accepted transfer and removes the additive stream cipher. The key stream is produced by an 11-bit shift register built on the polynomial x^11 + x^9 + 1. The block acquires the key by assuming the far end is sending idle (all ones). It loads eleven recovered key bits. It then confirms lock over a run of correct predictions.

Once locked, the block watches the descrambled stream. Lock is held only while every monitoring window contains a run of consecutive ones of at least a minimum length. A window that ends without such a run drops the block back to acquisition. A status output is high whenever the block is not locked. In 10 Mbit/s mode, or when bypass is set, bits pass through unchanged and the lock machine is held in acquisition.

The data side is a stream. The input has valid/ready, and the output has valid/ready with a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, the output bit is held and no new bit is accepted. Code-group alignment and symbol decoding are done downstream.

Top module: `dsc_descrambler`

## Requirements
- R1: A synchronous reset empties the output register (out_valid low) and puts the block in acquisition with sync_lost high.
- R2: in_ready equals (not out_valid) or out_ready. An accepted bit appears on out_bit with out_valid high in the next cycle. While out_valid is high and out_ready is low, out_valid and out_bit hold.
- R3: Outside bypass and in 100 Mbit/s mode, out_bit is the input bit XOR the key bit. Key bit n equals key bit n-11 XOR key bit n-9.
- R4: Acquisition takes the first 11 accepted bits as key bits equal to the inverted input. It then needs VERIFY_LEN consecutive bits whose inverted value matches the predicted key. sync_lost falls the cycle after the last of these bits.
- R5: A verifying bit whose inverted value differs from the predicted key restarts loading. That bit counts as the first of the 11 loaded key bits.
- R6: While locked, a window is WINDOW accepted bits, with the first window starting right after lock. If a window holds a run of at least RUN_LEN consecutive descrambled ones, the block stays locked and a new window starts.
- R7: A window that ends without such a run drops lock, with sync_lost high the cycle after its last bit. The block then restarts acquisition from an empty load.
- R8: With fast_mode low (10 Mbit/s), out_bit equals the accepted input bit. sync_lost is high from the next cycle on, and acquisition is cleared.
- R9: With bypass high, out_bit equals the accepted input bit. sync_lost is high from the next cycle on, and acquisition is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can take a bit this cycle |
| in_bit | input | 1 | Recovered scrambled line bit |
| fast_mode | input | 1 | High for 100 Mbit/s operation |
| bypass | input | 1 | High to pass bits unscrambled |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Descrambled bit |
| sync_lost | output | 1 | High while not locked |

## Verification
Every result of this block is due one cycle after the clock edge that accepts, or decides on, a bit. The descrambled bit and out_valid follow the accepting edge. sync_lost moves after the edge of the last verifying bit or the last window bit. The hold and bypass effects show after the first edge that sees the control input. The bench updates its behavioural model on the same edge and compares mid-cycle, after every register has settled. The directed checks read sync_lost just after the edge of the bit counted as deciding: the 71st acquisition bit, the last bit of a window, and the 81st bit after a verify mismatch.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } sync_state_t;
endpackage

// File: rtl/dsc_keygen.sv
module dsc_keygen #(
  parameter int KEY_W = 11,
  parameter int TAP   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic shift_bit,
  output logic pred
);
  localparam int HI = KEY_W - 1;
  localparam int TI = TAP - 1;

  // hist[k] holds the key bit k+1 positions back
  logic [KEY_W-1:0] hist;

  assign pred = hist[HI] ^ hist[TI];

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[KEY_W-2:0], shift_bit};
  end
endmodule

// File: rtl/dsc_syncfsm.sv
module dsc_syncfsm
  import dsc_pkg::*;
#(
  parameter int KEY_W      = 11,
  parameter int VERIFY_LEN = 60
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hold,
  input  logic        acc,
  input  logic        rec_key,
  input  logic        pred,
  input  logic        win_fail,
  output sync_state_t state,
  output logic        shift_bit
);
  localparam int MAXC = (KEY_W > VERIFY_LEN) ? KEY_W : VERIFY_LEN;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOAD_LAST = CW'(KEY_W - 1);
  localparam logic [CW-1:0] VER_LAST  = CW'(VERIFY_LEN - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] cnt;

  assign shift_bit = (state == ST_LOCK) ? pred : rec_key;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else if (acc) begin
      unique case (state)
        ST_LOAD: begin
          if (cnt == LOAD_LAST) begin
            state <= ST_VERIFY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_VERIFY: begin
          if (rec_key != pred) begin
            state <= ST_LOAD;
            cnt   <= ONE;
          end else if (cnt == VER_LAST) begin
            state <= ST_LOCK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_LOCK: begin
          if (win_fail) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        default: begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dsc_runmon.sv
module dsc_runmon #(
  parameter int WINDOW  = 125000,
  parameter int RUN_LEN = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic active,
  input  logic dbit,
  output logic win_fail
);
  localparam int WW = $clog2(WINDOW);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(RUN_LEN);

  logic [WW-1:0] win;
  logic [RW-1:0] run;
  logic          seen;
  logic [RW-1:0] run_nx;
  logic          seen_nx;
  logic          last;

  always_comb begin
    if (!dbit)               run_nx = '0;
    else if (run == RUN_MAX) run_nx = run;
    else                     run_nx = run + RW'(1);
    seen_nx = seen || (run_nx == RUN_MAX);
    last    = (win == WIN_LAST);
  end

  assign win_fail = active && last && !seen_nx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win  <= '0;
      run  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      if (last) begin
        win  <= '0;
        run  <= '0;
        seen <= 1'b0;
      end else begin
        win  <= win + WW'(1);
        run  <= run_nx;
        seen <= seen_nx;
      end
    end
  end
endmodule

// File: rtl/dsc_descrambler.sv
module dsc_descrambler
  import dsc_pkg::*;
#(
  parameter int KEY_W      = 11,
  parameter int TAP        = 9,
  parameter int VERIFY_LEN = 60,
  parameter int WINDOW     = 125000,
  parameter int RUN_LEN    = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic fast_mode,
  input  logic bypass,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic sync_lost
);
  logic        acc;
  logic        hold;
  logic        pred;
  logic        dbit;
  logic        shift_bit;
  logic        win_fail;
  sync_state_t state;

  assign in_ready  = !out_valid || out_ready;
  assign acc       = in_valid && in_ready;
  assign hold      = bypass || !fast_mode;
  assign dbit      = in_bit ^ pred;
  assign sync_lost = (state != ST_LOCK);

  dsc_keygen #(.KEY_W(KEY_W), .TAP(TAP)) u_key (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (acc && !hold),
    .shift_bit (shift_bit),
    .pred      (pred)
  );

  dsc_syncfsm #(.KEY_W(KEY_W), .VERIFY_LEN(VERIFY_LEN)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .acc       (acc),
    .rec_key   (!in_bit),
    .pred      (pred),
    .win_fail  (win_fail),
    .state     (state),
    .shift_bit (shift_bit)
  );

  dsc_runmon #(.WINDOW(WINDOW), .RUN_LEN(RUN_LEN)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .clear    (hold || state != ST_LOCK),
    .active   (acc && !hold && state == ST_LOCK),
    .dbit     (dbit),
    .win_fail (win_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_bit   <= hold ? in_bit : dbit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsc_descrambler_chk.sv
module dsc_descrambler_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_bit,
  input logic fast_mode,
  input logic bypass,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic sync_lost
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sync_lost && !out_valid)); // R1

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R2

  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_lost) |-> $past(in_valid && in_ready && fast_mode && !bypass)); // R4

  AST_SLOW_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !fast_mode |=> sync_lost); // R8

  AST_BYPASS_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    bypass |=> sync_lost); // R9

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (bypass || !fast_mode)) |=> (out_bit == $past(in_bit))); // R9
endmodule

bind dsc_descrambler dsc_descrambler_chk u_chk (.*);

// File: tb/dsc_descrambler_test.sv
`timescale 1ns/1ps
module dsc_descrambler_test;
  localparam int VLEN = 60;
  localparam int WIN  = 300;
  localparam int RUN  = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, fast_mode = 1'b1, bypass = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, sync_lost;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dsc_descrambler #(.VERIFY_LEN(VLEN), .WINDOW(WIN), .RUN_LEN(RUN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .fast_mode(fast_mode), .bypass(bypass), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .sync_lost(sync_lost));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // transmit-side scrambler model
  bit txq[$];
  function automatic bit scramble(input bit plain);
    bit k;
    k = txq[txq.size()-11] ^ txq[txq.size()-9];
    txq.push_back(k);
    if (txq.size() > 11) void'(txq.pop_front());
    return plain ^ k;
  endfunction

  // behavioural reference model
  bit mq[$];
  int m_st, m_cnt, m_run, m_win;
  bit m_seen, m_ov, m_ob;

  always @(posedge clk) begin
    bit hold, acc, pr, d, rk;
    if (rst) begin
      mq = {};
      for (int i = 0; i < 11; i++) mq.push_back(1'b0);
      m_st = 0; m_cnt = 0; m_run = 0; m_win = 0; m_seen = 0; m_ov = 0; m_ob = 0;
    end else begin
      hold = bypass || !fast_mode;
      acc  = in_valid && (!m_ov || out_ready);
      pr   = mq[mq.size()-11] ^ mq[mq.size()-9];
      d    = in_bit ^ pr;
      rk   = !in_bit;
      if (acc) begin m_ov = 1; m_ob = hold ? in_bit : d; end
      else if (out_ready) m_ov = 0;
      if (hold) begin
        m_st = 0; m_cnt = 0; m_run = 0; m_win = 0; m_seen = 0;
      end else if (acc) begin
        if (m_st == 0) begin
          mq.push_back(rk); m_cnt++;
          if (m_cnt == 11) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
          mq.push_back(rk);
          if (rk == pr) begin
            m_cnt++;
            if (m_cnt == VLEN) begin m_st = 2; m_cnt = 0; m_run = 0; m_win = 0; m_seen = 0; end
          end else begin
            m_st = 0; m_cnt = 1;
          end
        end else begin
          mq.push_back(pr);
          m_run = d ? ((m_run < RUN) ? m_run + 1 : RUN) : 0;
          if (m_run >= RUN) m_seen = 1;
          m_win++;
          if (m_win == WIN) begin
            if (!m_seen) begin m_st = 0; m_cnt = 0; end
            m_win = 0; m_run = 0; m_seen = 0;
          end
        end
      end
      if (mq.size() > 11) void'(mq.pop_front());
    end
  end

  // per-cycle comparison, mid-cycle
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      chk(out_valid == m_ov, "R2 out_valid", out_valid, m_ov);
      chk(in_ready == (!m_ov || out_ready), "R2 in_ready", in_ready, !m_ov || out_ready);
      if (m_ov) chk(out_bit == m_ob, "R3 out_bit", out_bit, m_ob);
      chk(sync_lost == (m_st != 2), "R4 sync_lost", sync_lost, m_st != 2);
    end
  end

  bit last_scr;

  task automatic send_bit(input bit plain);
    bit r;
    @(negedge clk);
    last_scr = scramble(plain);
    in_valid = 1'b1; in_bit = last_scr;
    #1 r = in_ready;
    while (!r) begin @(negedge clk); #1 r = in_ready; end
    @(posedge clk); #1;
  endtask

  task automatic send_n(input int n, input bit plain);
    for (int i = 0; i < n; i++) send_bit(plain);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    bit held;
    for (int i = 0; i < 11; i++) txq.push_back(bit'((11'h59D >> i) & 1));
    repeat (3) @(posedge clk);
    #1;
    chk(sync_lost == 1'b1, "R1 sync_lost after reset", sync_lost, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    @(negedge clk); rst = 1'b0;

    // R4: acquisition from idle
    send_n(70, 1'b1);
    chk(sync_lost == 1'b1, "R4 still acquiring at bit 70", sync_lost, 1);
    send_bit(1'b1);
    chk(sync_lost == 1'b0, "R4 locked after bit 71", sync_lost, 0);
    idle(3);

    // R6: two windows each holding a long run of ones
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < 200; i++) send_bit(bit'($urandom_range(0, 1)) & bit'(i % 7 != 0));
      send_n(30, 1'b1);
      for (int i = 0; i < 70; i++) begin
        send_bit(bit'(i % 2));
        if (i == 5) chk(out_bit == 1'b1, "R3 descrambled data", out_bit, 1);
        if (i == 6) chk(out_bit == 1'b0, "R3 descrambled data", out_bit, 0);
      end
    end
    chk(sync_lost == 1'b0, "R6 lock held over two windows", sync_lost, 0);

    // R7: window with no long run
    for (int i = 0; i < 299; i++) send_bit(bit'(i % 2));
    chk(sync_lost == 1'b0, "R7 locked before window end", sync_lost, 0);
    send_bit(1'b0);
    chk(sync_lost == 1'b1, "R7 lock dropped at window end", sync_lost, 1);

    // R5: mismatch during verify restarts loading
    send_n(41, 1'b1);
    send_bit(1'b0);
    send_n(80, 1'b1);
    chk(sync_lost == 1'b1, "R5 not locked 80 bits after mismatch", sync_lost, 1);
    send_bit(1'b1);
    chk(sync_lost == 1'b0, "R5 locked 81 bits after mismatch", sync_lost, 0);

    // R2: back-pressure
    idle(2);
    @(negedge clk); out_ready = 1'b0;
    send_bit(1'b1);
    held = out_bit;
    @(negedge clk); in_valid = 1'b0; #1;
    chk(in_ready == 1'b0, "R2 in_ready low while stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    #1 chk(out_bit == held && out_valid, "R2 output held during stall", out_bit, held);
    out_ready = 1'b1;
    idle(2);

    // R8: 10 Mbit/s mode
    @(negedge clk); fast_mode = 1'b0;
    @(posedge clk); #1;
    chk(sync_lost == 1'b1, "R8 slow mode unlocks", sync_lost, 1);
    send_bit(1'b0);
    chk(out_bit == last_scr, "R8 slow mode passes input", out_bit, last_scr);
    send_bit(1'b1);
    chk(out_bit == last_scr, "R8 slow mode passes input", out_bit, last_scr);
    @(negedge clk); fast_mode = 1'b1; in_valid = 1'b0;

    // R9: bypass
    send_n(71, 1'b1);
    chk(sync_lost == 1'b0, "R9 relocked before bypass", sync_lost, 0);
    @(negedge clk); bypass = 1'b1;
    @(posedge clk); #1;
    chk(sync_lost == 1'b1, "R9 bypass unlocks", sync_lost, 1);
    send_bit(1'b0);
    chk(out_bit == last_scr, "R9 bypass passes input", out_bit, last_scr);
    @(negedge clk); bypass = 1'b0; in_valid = 1'b0;
    send_n(70, 1'b1);
    chk(sync_lost == 1'b1, "R9 acquisition restarted after bypass", sync_lost, 1);
    send_bit(1'b1);
    chk(sync_lost == 1'b0, "R9 relocked after bypass", sync_lost, 0);
    idle(4);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule